// File: doc/BRIEF.md
# Gated Periodic Pulse Counter

This block counts low-to-high transitions of a pulse input over repeated, fixed-length gate windows. A direction input chooses between counting up and counting down. When a window closes, the running total is copied into a result register, and the live counter begins again from zero. The result then holds steady until the next window closes.

A host reaches the block through three items: an 8-bit control byte, an 8-bit status byte and the 32-bit result. The control byte starts and stops the windowed counting and drives two general-purpose outputs. The status byte shows whether counting is running, echoes the two outputs and the synchronized direction, and carries a toggle bit. The toggle bit flips once for each new result, so the host can see a fresh value without any further handshake.

The window length is a parameter given in clock cycles. At a 50 MHz clock, the default is 10 seconds. The gate is a two-state machine with the states GATE_IDLE and GATE_RUN and three transitions:
- START moves GATE_IDLE to GATE_RUN when the start bit is set.
- STOP moves GATE_RUN to GATE_IDLE when the start bit is cleared.
- WRAP keeps the machine in GATE_RUN at the last cycle of a window, raises the window-end strobe and resets the window timer.

Top module: `gated_pulse_counter`

## Requirements
- R1: The pulse input passes through a two-flop synchronizer. Only its low-to-high transitions are counted, so a level held high for many cycles adds exactly one.
- R2: When the synchronized direction is high, each counted edge adds one. When it is low, each counted edge subtracts one. The counter wraps modulo 2^32, so three down-counts from zero give 0xFFFFFFFD.
- R3: A window lasts WINDOW_CYCLES clock cycles, and the first window is measured from the START transition. At the end of each window, the live count is copied into `result_o` and the live count restarts from zero.
- R4: `result_o` changes only at a window end and holds its value in every other cycle.
- R5: Control bit 2 drives `gp_o1` and control bit 3 drives `gp_o2`, each one clock later. Status bit 2 mirrors `gp_o1` and status bit 3 mirrors `gp_o2`.
- R6: Control bit 5 is the start bit. Status bit 5 is high while the gate is running and follows the start bit one clock later.
- R7: Status bit 0 inverts in the same cycle that a new result appears, once per window end, and never changes while counting is stopped.
- R8: Status bit 1 shows the direction input after the two-flop synchronizer. Status bits 7, 6 and 4 are always zero.
- R9: Clearing the start bit returns the gate to GATE_IDLE, resets the window timer and clears the live count, and the last result is kept. A later START gives a full-length first window that starts counting from zero.
- R10: An edge detected in the last cycle of a window is not included in that window's result. It is counted into the next window.
- R11: After reset, the status byte, `result_o`, `gp_o1` and `gp_o2` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Raw pulse input to be counted |
| dir_in | input | 1 | Raw direction input: high counts up, low counts down |
| ctrl_byte | input | 8 | Control byte: bit 5 start, bit 3 output 2, bit 2 output 1 |
| status_byte | output | 8 | Status byte: bit 5 running, bit 3/2 outputs, bit 1 direction, bit 0 toggle |
| result_o | output | 32 | Count latched at the last window end |
| gp_o1 | output | 1 | General-purpose output 1 |
| gp_o2 | output | 1 | General-purpose output 2 |

## Verification
The properties assume that the control byte is held at zero during reset. They also assume that, after reset, the only way status bit 5 rises or status bit 0 flips is through the gate machine. The window-length property therefore counts running cycles in the checker and expects exactly WINDOW_CYCLES of them between toggle flips.

The stimulus changes inputs only on falling clock edges. It spaces pulses at least two cycles apart so that no edge is lost in the synchronizer, and it sets the direction before the first pulse of each window. Except in the test aimed at R10, it keeps every pulse clear of the window boundary.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_e;

    localparam int CTRL_START_BIT = 5;
    localparam int CTRL_OUT2_BIT  = 3;
    localparam int CTRL_OUT1_BIT  = 2;

    localparam int STAT_RUN_BIT   = 5;
    localparam int STAT_OUT2_BIT  = 3;
    localparam int STAT_OUT1_BIT  = 2;
    localparam int STAT_DIR_BIT   = 1;
    localparam int STAT_TOG_BIT   = 0;

endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/gpc_edge.sv
module gpc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/gpc_gate_fsm.sv
module gpc_gate_fsm
    import gpc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o,
    output logic win_end_o
);

    localparam int TMR_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WINDOW_CYCLES - 1);

    gate_state_e      state_q, state_d;
    logic [TMR_W-1:0] timer_q;
    logic             at_last;

    assign at_last = (timer_q == TMR_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, STOP, WRAP (WRAP stays in GATE_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (start_i)  state_d = GATE_RUN;
            GATE_RUN:  if (!start_i) state_d = GATE_IDLE;
            default:   state_d = GATE_IDLE;
        endcase
    end

    // window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (state_q == GATE_RUN && state_d == GATE_RUN) begin
            timer_q <= at_last ? '0 : timer_q + 1'b1;
        end else begin
            timer_q <= '0;
        end
    end

    // outputs
    always_comb begin
        running_o = 1'b0;
        win_end_o = 1'b0;
        unique case (state_q)
            GATE_IDLE: begin
                running_o = 1'b0;
                win_end_o = 1'b0;
            end
            GATE_RUN: begin
                running_o = 1'b1;
                win_end_o = at_last;
            end
            default: begin
                running_o = 1'b0;
                win_end_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpc_accum.sv
module gpc_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             win_end_i,
    input  logic             rise_i,
    input  logic             up_i,
    output logic [CNT_W-1:0] result_o,
    output logic             toggle_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MONE = {CNT_W{1'b1}};

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] step;

    assign step = rise_i ? (up_i ? ONE : MONE) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (!running_i) begin
            live_q <= '0;
        end else if (win_end_i) begin
            live_q <= step;
        end else begin
            live_q <= live_q + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            toggle_o <= 1'b0;
        end else if (win_end_i) begin
            result_o <= live_q;
            toggle_o <= ~toggle_o;
        end
    end

endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter
    import gpc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 500_000_000,
    parameter int CNT_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             dir_in,
    input  logic [7:0]       ctrl_byte,
    output logic [7:0]       status_byte,
    output logic [CNT_W-1:0] result_o,
    output logic             gp_o1,
    output logic             gp_o2
);

    logic [1:0] raw_in, sync_in;
    logic       pulse_s, dir_s;
    logic       rise;
    logic       running, win_end;
    logic       toggle;
    logic       unused_ctrl;

    assign raw_in  = {dir_in, pulse_in};
    assign pulse_s = sync_in[0];
    assign dir_s   = sync_in[1];
    assign unused_ctrl = ^{ctrl_byte[7:6], ctrl_byte[4], ctrl_byte[1:0]};

    gpc_sync #(.WIDTH(2), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    gpc_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pulse_s),
        .rise_o  (rise)
    );

    gpc_gate_fsm #(.WINDOW_CYCLES(WINDOW_CYCLES)) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (ctrl_byte[CTRL_START_BIT]),
        .running_o (running),
        .win_end_o (win_end)
    );

    gpc_accum #(.CNT_W(CNT_W)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .running_i (running),
        .win_end_i (win_end),
        .rise_i    (rise),
        .up_i      (dir_s),
        .result_o  (result_o),
        .toggle_o  (toggle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_o1 <= 1'b0;
            gp_o2 <= 1'b0;
        end else begin
            gp_o1 <= ctrl_byte[CTRL_OUT1_BIT];
            gp_o2 <= ctrl_byte[CTRL_OUT2_BIT];
        end
    end

    always_comb begin
        status_byte                = '0;
        status_byte[STAT_RUN_BIT]  = running;
        status_byte[STAT_OUT2_BIT] = gp_o2;
        status_byte[STAT_OUT1_BIT] = gp_o1;
        status_byte[STAT_DIR_BIT]  = dir_s;
        status_byte[STAT_TOG_BIT]  = toggle;
    end

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int WINDOW_CYCLES = 500_000_000,
    parameter int CNT_W         = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl_byte,
    input logic [7:0]       status_byte,
    input logic [CNT_W-1:0] result_o,
    input logic             gp_o1,
    input logic             gp_o2
);

    logic [31:0] run_cnt;
    logic        tog_prev;
    logic        flip;

    assign flip = status_byte[0] != tog_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            tog_prev <= 1'b0;
        end else begin
            tog_prev <= status_byte[0];
            if (!status_byte[5])  run_cnt <= '0;
            else if (flip)        run_cnt <= 32'd1;
            else                  run_cnt <= run_cnt + 32'd1;
        end
    end

    // R3: the checker's own count of running cycles between flips equals the window length
    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && status_byte[5]) |-> run_cnt == 32'(WINDOW_CYCLES));

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status_byte[0]) |-> $stable(result_o));

    assert_gp1_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gp_o1) |-> $past(ctrl_byte[2]));

    assert_gp2_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gp_o2) |-> $past(ctrl_byte[3]));

    assert_start_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[5]) |-> $past(ctrl_byte[5]));

    assert_stop_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[5]) |-> !$past(ctrl_byte[5]));

    assert_flip_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_byte[0]) |-> $past(status_byte[5]));

endmodule

bind gated_pulse_counter gpc_checker #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .CNT_W         (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_byte   (ctrl_byte),
    .status_byte (status_byte),
    .result_o    (result_o),
    .gp_o1       (gp_o1),
    .gp_o2       (gp_o2)
);

// File: tb/gated_pulse_counter_tb_top.sv
`timescale 1ns/1ps
module gated_pulse_counter_tb_top;

    localparam int W = 64;

    typedef struct packed {
        logic        dir;
        logic [7:0]  npulse;
        logic [7:0]  hi;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd5,  8'd2,  32'd5},          // R2 up
        '{1'b1, 8'd0,  8'd2,  32'd0},          // R3 empty window
        '{1'b0, 8'd3,  8'd2,  32'hFFFF_FFFD},  // R2 down wrap
        '{1'b1, 8'd2,  8'd20, 32'd2},          // R1 long high counts once
        '{1'b1, 8'd12, 8'd2,  32'd12}          // R2 up, many
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pulse_in, dir_in;
    logic [7:0]  ctrl_byte;
    logic [7:0]  status_byte;
    logic [31:0] result_o;
    logic        gp_o1, gp_o2;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gated_pulse_counter #(.WINDOW_CYCLES(W), .CNT_W(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_in    (pulse_in),
        .dir_in      (dir_in),
        .ctrl_byte   (ctrl_byte),
        .status_byte (status_byte),
        .result_o    (result_o),
        .gp_o1       (gp_o1),
        .gp_o2       (gp_o2)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wait_flip(output int cycles);
        logic t;
        t = status_byte[0];
        cycles = 0;
        while (status_byte[0] == t && cycles < 4 * W) begin
            @(negedge clk);
            cycles++;
        end
        if (cycles >= 4 * W) check("R7", "toggle timeout", 32'(cycles), 32'(W));
    endtask

    task automatic pulses(int n, int hi);
        for (int k = 0; k < n; k++) begin
            pulse_in = 1'b1;
            repeat (hi) @(negedge clk);
            pulse_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] prev_exp;
        logic [31:0] kept;
        logic        tkeep;

        rst_n = 1'b0; pulse_in = 1'b0; dir_in = 1'b0; ctrl_byte = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "status after reset", {24'd0, status_byte}, 32'd0);
        check("R11", "result after reset", result_o, 32'd0);
        check("R11", "outputs after reset", {30'd0, gp_o2, gp_o1}, 32'd0);

        // R5 outputs follow control bits
        ctrl_byte = 8'h04;
        @(negedge clk);
        check("R5", "gp pins for 0x04", {30'd0, gp_o2, gp_o1}, 32'd1);
        check("R5", "status mirror for 0x04", {30'd0, status_byte[3:2]}, 32'd1);
        ctrl_byte = 8'h08;
        @(negedge clk);
        check("R5", "gp pins for 0x08", {30'd0, gp_o2, gp_o1}, 32'd2);

        // R8 direction mirror and reserved bits
        dir_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "status dir bit", {31'd0, status_byte[1]}, 32'd1);
        check("R8", "reserved status bits", {29'd0, status_byte[7:6], status_byte[4]}, 32'd0);

        // R6 start
        ctrl_byte = 8'h28;
        wait_flip(cyc);
        check("R6", "running bit", {31'd0, status_byte[5]}, 32'd1);
        check("R3", "first window length from start", 32'(cyc), 32'(W + 1));
        wait_flip(cyc);
        check("R3", "window length flip to flip", 32'(cyc), 32'(W));
        check("R3", "empty window result", result_o, 32'd0);
        prev_exp = 32'd0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            dir_in = VECS[i].dir;
            @(negedge clk);
            pulses(int'(VECS[i].npulse), int'(VECS[i].hi));
            check("R4", $sformatf("result held mid-window vec %0d", i), result_o, prev_exp);
            wait_flip(cyc);
            check("R2", $sformatf("window result vec %0d", i), result_o, VECS[i].exp);
            prev_exp = VECS[i].exp;
        end

        // R10 edge at window boundary goes to the next window
        dir_in = 1'b1;
        pulses(2, 2);
        repeat (W - 3 - 8) @(negedge clk);
        pulse_in = 1'b1;
        repeat (2) @(negedge clk);
        wait_flip(cyc);
        pulse_in = 1'b0;
        check("R10", "boundary edge excluded", result_o, 32'd2);
        wait_flip(cyc);
        check("R10", "boundary edge in next window", result_o, 32'd1);

        // R9 stop keeps result, freezes toggle, clears live count
        pulses(3, 2);
        ctrl_byte = 8'h00;
        kept  = result_o;
        tkeep = status_byte[0];
        @(negedge clk);
        check("R9", "running bit cleared", {31'd0, status_byte[5]}, 32'd0);
        repeat (2 * W) @(negedge clk);
        check("R7", "toggle frozen while stopped", {31'd0, status_byte[0]}, {31'd0, tkeep});
        check("R9", "result kept while stopped", result_o, kept);

        ctrl_byte = 8'h20;
        pulses(4, 2);
        wait_flip(cyc);
        check("R9", "restart full window", 32'(cyc + 16), 32'(W + 1));
        check("R9", "restart counts from zero", result_o, 32'd4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule